// File: doc/BRIEF.md
# Dual-Channel Stepped Soft-Start Sequencer

This block generates two digital reference codes for a power controller: one for the switching regulator's error amplifier and one for the linear regulator's error amplifier. A downstream DAC turns each code into a voltage, with one code step worth roughly 20 mV at the feedback node. When the supply monitor reports a valid supply, the part is enabled and no fault is present, both codes climb from zero as a staircase. Each step lasts a fixed number of oscillator clock cycles, so the ramp time scales with the switching frequency.

The switching channel starts climbing as soon as the block is allowed to run. The linear channel waits a fixed number of cycles before it starts, so it reaches the final value that many cycles after the switching channel. Losing the supply, disabling the part or raising a fault sends both codes back to zero. A later restart begins the ramp again from the bottom.

Each channel reports when its code has reached the final value. A combined flag shows that both channels have finished.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both codes and all three done flags are 0 after that edge.
- R2: The block may ramp only at edges where `supply_ok`=1, `enable`=1 and `fault`=0 are all true; if any one of them fails, both codes stay at 0.
- R3: While the block may ramp, the switching code equals floor(N/STEP_CYCLES), where N is the number of consecutive qualifying edges (default 32 cycles per step). It therefore rises by exactly one code per step.
- R4: Both codes saturate at FINAL_CODE (default 40, i.e. 0.8 V at 20 mV per code). They never exceed it and never wrap, however long the run lasts.
- R5: The linear code is 0 for the first LAG_CYCLES qualifying edges (default 320). After that it equals floor((N-LAG_CYCLES)/STEP_CYCLES), capped at FINAL_CODE, so it reaches the final value LAG_CYCLES after the switching code does.
- R6: At the first edge where the ramp condition of R2 is false, both codes and all done flags go to 0.
- R7: After a clear, a restart begins from code 0 with a full fresh step count. A partly counted step from before the clear is discarded.
- R8: `sw_ramp_done` and `lin_ramp_done` are 1 exactly in the cycles where the matching code equals FINAL_CODE. Each rises in the first such cycle.
- R9: `all_ramps_done` is 1 exactly when both channel done flags are 1.
- R10: From one cycle to the next, a code either keeps its value, rises by exactly one, or drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply monitor reports its rising threshold has been exceeded |
| enable | input | 1 | Part enable; low inhibits both outputs |
| fault | input | 1 | Protection fault; high clears both ramps |
| sw_ref_code | output | CODE_W (6) | Switching-channel reference code, 1 LSB = 20 mV |
| lin_ref_code | output | CODE_W (6) | Linear-channel reference code, 1 LSB = 20 mV |
| sw_ramp_done | output | 1 | Switching code is at its final value |
| lin_ramp_done | output | 1 | Linear code is at its final value |
| all_ramps_done | output | 1 | Both channels are at their final value |

## Verification
The bench builds the block with its default values: 40 steps, 32 cycles per step and a 320-cycle lag. At these values a complete two-channel sequence takes 1600 cycles, so the bench can run it end to end several times. This covers the exact step edges, the 320-cycle gap between the two done flags, and the long hold at saturation. It also covers aborts during the switching-only phase and during the overlap phase, plus a restart after an abort that left a step partly counted.

// File: rtl/ss_seq_pkg.sv
// Package: ss_seq_pkg
// Shared channel indices and a width helper for the soft-start sequencer.
// Assumes: only two channels exist; index 0 leads, index 1 lags.
package ss_seq_pkg;
    typedef enum int {CH_SW = 0, CH_LIN = 1} ss_chan_e;

    localparam int NUM_CH = 2;

    // Bits needed to hold values 0..n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ss_run_qual.sv
// Module: ss_run_qual
// Combines the supply-good, enable and fault inputs into one run permission.
// Assumes: all three inputs are already synchronous to the oscillator clock.
module ss_run_qual (
    input  logic supply_ok,
    input  logic enable,
    input  logic fault,
    output logic run
);
    // Ramping is allowed only with a good supply, the part enabled and no fault.
    always_comb begin
        run = supply_ok & enable & ~fault;
    end
endmodule

// File: rtl/ss_lag_timer.sv
// Module: ss_lag_timer
// Counts qualifying cycles until the lag before the trailing channel has elapsed.
// Assumes: run low clears the count; the count holds once it reaches the limit.
module ss_lag_timer #(
    parameter int LAG_CYCLES = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic lag_done
);
    localparam int LW = ss_seq_pkg::cnt_width(LAG_CYCLES + 1);
    localparam logic [LW-1:0] LAG_LIMIT = LW'(LAG_CYCLES);

    logic [LW-1:0] lag_cnt;

    // Advance the lag count while running and stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            lag_cnt <= '0;
        end else if (lag_cnt != LAG_LIMIT) begin
            lag_cnt <= lag_cnt + 1'b1;
        end
    end

    // The trailing channel may advance once the limit has been reached.
    always_comb begin
        lag_done = (lag_cnt == LAG_LIMIT);
    end
endmodule

// File: rtl/ss_step_ramp.sv
// Module: ss_step_ramp
// One staircase channel: holds each code for STEP_CYCLES advancing cycles,
// then raises it by one, and stops at FINAL_CODE.
// Assumes: clear has priority over advance; the step count freezes at saturation.
module ss_step_ramp #(
    parameter int FINAL_CODE  = 40,
    parameter int STEP_CYCLES = 32,
    parameter int CODE_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int SW = ss_seq_pkg::cnt_width(STEP_CYCLES);
    localparam logic [SW-1:0]     STEP_LAST = SW'(STEP_CYCLES - 1);
    localparam logic [CODE_W-1:0] CODE_TOP  = CODE_W'(FINAL_CODE);

    logic [SW-1:0]     step_cnt;
    logic [CODE_W-1:0] code_q;

    // Count cycles within the current step and bump the code at the step's end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            step_cnt <= '0;
            code_q   <= '0;
        end else if (advance && (code_q != CODE_TOP)) begin
            if (step_cnt == STEP_LAST) begin
                step_cnt <= '0;
                code_q   <= code_q + 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    // Present the code and flag the final value.
    always_comb begin
        code = code_q;
        done = (code_q == CODE_TOP);
    end
endmodule

// File: rtl/softstart_seq.sv
// Module: softstart_seq
// Top of the dual-channel stepped soft-start sequencer. The switching channel
// ramps as soon as running is allowed; the linear channel starts LAG_CYCLES later.
// Assumes: clock is the oscillator clock; reset is synchronous and active low.
module softstart_seq #(
    parameter int FINAL_CODE  = 40,
    parameter int STEP_CYCLES = 32,
    parameter int LAG_CYCLES  = 320,
    localparam int CODE_W     = ss_seq_pkg::cnt_width(FINAL_CODE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              enable,
    input  logic              fault,
    output logic [CODE_W-1:0] sw_ref_code,
    output logic [CODE_W-1:0] lin_ref_code,
    output logic              sw_ramp_done,
    output logic              lin_ramp_done,
    output logic              all_ramps_done
);
    import ss_seq_pkg::*;

    logic run;
    logic halt;
    logic lag_done;
    logic [CODE_W-1:0] ch_code [NUM_CH];
    logic [NUM_CH-1:0] ch_done;

    ss_run_qual u_qual (
        .supply_ok (supply_ok),
        .enable    (enable),
        .fault     (fault),
        .run       (run)
    );

    // Both channels clear whenever running is not allowed.
    always_comb begin
        halt = ~run;
    end

    ss_lag_timer #(
        .LAG_CYCLES (LAG_CYCLES)
    ) u_lag (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .lag_done (lag_done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic adv;
        if (ch == int'(CH_SW)) begin : g_lead
            // The leading channel advances on every running cycle.
            always_comb adv = run;
        end else begin : g_trail
            // The trailing channel advances only after the lag has elapsed.
            always_comb adv = run & lag_done;
        end

        ss_step_ramp #(
            .FINAL_CODE  (FINAL_CODE),
            .STEP_CYCLES (STEP_CYCLES),
            .CODE_W      (CODE_W)
        ) u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (halt),
            .advance (adv),
            .code    (ch_code[ch]),
            .done    (ch_done[ch])
        );
    end

    // Route the channel results to the ports and combine the done flags.
    always_comb begin
        sw_ref_code    = ch_code[CH_SW];
        lin_ref_code   = ch_code[CH_LIN];
        sw_ramp_done   = ch_done[CH_SW];
        lin_ramp_done  = ch_done[CH_LIN];
        all_ramps_done = &ch_done;
    end
endmodule

// File: rtl/softstart_seq_checker.sv
// Module: softstart_seq_checker
// Temporal checks on the sequencer ports; attached to every softstart_seq by bind.
// Assumes: bench starts with rst_n low before the first clock edge.
module softstart_seq_checker #(
    parameter int FINAL_CODE = 40,
    parameter int CODE_W     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              enable,
    input logic              fault,
    input logic [CODE_W-1:0] sw_ref_code,
    input logic [CODE_W-1:0] lin_ref_code,
    input logic              sw_ramp_done,
    input logic              lin_ramp_done,
    input logic              all_ramps_done
);
    localparam logic [CODE_W-1:0] TOP  = CODE_W'(FINAL_CODE);
    localparam logic [CODE_W-1:0] NEAR = CODE_W'(FINAL_CODE - 1);

    // R1: reset clears both codes and the flags.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (sw_ref_code == '0) && (lin_ref_code == '0) && !all_ramps_done);

    // R4: codes never pass the final value.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ref_code <= TOP) && (lin_ref_code <= TOP));

    // R6: losing the run condition clears both codes on the next edge.
    a_r6_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !(supply_ok && enable && !fault) |=> (sw_ref_code == '0) && (lin_ref_code == '0));

    // R5: the linear channel is never ahead of the switching channel.
    a_r5_lin_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        lin_ref_code <= sw_ref_code);

    // R10: the switching code moves only by +1 or back to zero.
    a_r10_sw_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ref_code != $past(sw_ref_code)) |->
            ((sw_ref_code == $past(sw_ref_code) + 1'b1) || (sw_ref_code == '0)));

    // R10: the linear code moves only by +1 or back to zero.
    a_r10_lin_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_ref_code != $past(lin_ref_code)) |->
            ((lin_ref_code == $past(lin_ref_code) + 1'b1) || (lin_ref_code == '0)));

    // R8: the switching done flag rises on the step from the last code below final.
    a_r8_sw_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ramp_done) |-> ($past(sw_ref_code) == NEAR));

    // R8: the linear done flag is never raised below the final value.
    a_r8_lin_done_level: assert property (@(posedge clk) disable iff (!rst_n)
        lin_ramp_done |-> (lin_ref_code == TOP));

    // R9: the combined flag implies both codes are at the final value.
    a_r9_all_done: assert property (@(posedge clk) disable iff (!rst_n)
        all_ramps_done |-> (sw_ref_code == TOP) && (lin_ref_code == TOP));
endmodule

bind softstart_seq softstart_seq_checker #(
    .FINAL_CODE (FINAL_CODE),
    .CODE_W     (CODE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .enable         (enable),
    .fault          (fault),
    .sw_ref_code    (sw_ref_code),
    .lin_ref_code   (lin_ref_code),
    .sw_ramp_done   (sw_ramp_done),
    .lin_ramp_done  (lin_ramp_done),
    .all_ramps_done (all_ramps_done)
);

// File: tb/sim_softstart_seq.sv
// Bench for softstart_seq: a behavioural count of qualifying edges predicts
// both codes and all flags, compared after every clock.
module sim_softstart_seq;
    localparam int FINAL = 40;
    localparam int STEP  = 32;
    localparam int LAG   = 320;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic enable = 1'b0;
    logic fault = 1'b0;
    logic [5:0] sw_code;
    logic [5:0] lin_code;
    logic sw_done;
    logic lin_done;
    logic all_done;

    int checks = 0;
    int fails = 0;
    int run_n = 0;
    bit finished = 0;

    softstart_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .enable         (enable),
        .fault          (fault),
        .sw_ref_code    (sw_code),
        .lin_ref_code   (lin_code),
        .sw_ramp_done   (sw_done),
        .lin_ramp_done  (lin_done),
        .all_ramps_done (all_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_sw(input int n);
        int v = n / STEP;
        return (v > FINAL) ? FINAL : v;
    endfunction

    function automatic int exp_lin(input int n);
        int v;
        if (n <= LAG) return 0;
        v = (n - LAG) / STEP;
        return (v > FINAL) ? FINAL : v;
    endfunction

    // One clock: update the model at the edge, compare on the falling edge.
    task automatic tick();
        int es;
        int el;
        @(posedge clk);
        if (!rst_n || !(supply_ok && enable && !fault)) run_n = 0;
        else run_n++;
        @(negedge clk);
        es = exp_sw(run_n);
        el = exp_lin(run_n);
        chk(int'(sw_code) == es, "R3 sw code", int'(sw_code), es);
        chk(int'(lin_code) == el, "R5 lin code", int'(lin_code), el);
        chk(sw_done == (es == FINAL), "R8 sw done", int'(sw_done), int'(es == FINAL));
        chk(lin_done == (el == FINAL), "R8 lin done", int'(lin_done), int'(el == FINAL));
        chk(all_done == (es == FINAL && el == FINAL), "R9 all done",
            int'(all_done), int'(es == FINAL && el == FINAL));
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    initial begin
        // R1: reset state
        ticks(4);
        chk(sw_code == 0 && lin_code == 0 && !all_done, "R1 reset clear", int'(sw_code), 0);
        rst_n = 1'b1;

        // R2: each missing qualifier keeps the codes at zero
        supply_ok = 1'b1; enable = 1'b0;
        ticks(70);
        chk(sw_code == 0, "R2 disabled", int'(sw_code), 0);
        supply_ok = 1'b0; enable = 1'b1;
        ticks(70);
        chk(sw_code == 0, "R2 no supply", int'(sw_code), 0);
        supply_ok = 1'b1; fault = 1'b1;
        ticks(70);
        chk(sw_code == 0, "R2 fault held", int'(sw_code), 0);

        // R3/R5/R8/R9: full ramp, then a long hold at saturation (R4)
        fault = 1'b0;
        ticks(STEP - 1);
        chk(sw_code == 0, "R3 before first step", int'(sw_code), 0);
        ticks(1);
        chk(sw_code == 1, "R3 first step", int'(sw_code), 1);
        ticks(FINAL * STEP - STEP);
        chk(sw_done && !lin_done, "R5 sw done before lin", int'(lin_done), 0);
        ticks(LAG - 1);
        chk(!lin_done, "R5 lin one cycle short", int'(lin_done), 0);
        ticks(1);
        chk(lin_done && all_done, "R9 both done", int'(all_done), 1);
        ticks(500);
        chk(sw_code == FINAL && lin_code == FINAL, "R4 saturation hold", int'(lin_code), FINAL);

        // R6: supply loss after completion
        supply_ok = 1'b0;
        tick();
        chk(sw_code == 0 && lin_code == 0 && !sw_done, "R6 supply drop", int'(sw_code), 0);
        supply_ok = 1'b1;

        // R6: fault during the overlap phase
        ticks(LAG + 100);
        fault = 1'b1;
        tick();
        chk(sw_code == 0 && lin_code == 0, "R6 fault abort", int'(lin_code), 0);
        fault = 1'b0;

        // R7: restart discards a partly counted step
        ticks(20);
        enable = 1'b0;
        tick();
        enable = 1'b1;
        ticks(STEP - 1);
        chk(sw_code == 0, "R7 fresh step count", int'(sw_code), 0);
        ticks(1);
        chk(sw_code == 1, "R7 first step after restart", int'(sw_code), 1);

        // R6: enable drop during the switching-only phase, then reset mid-ramp (R1)
        ticks(200);
        enable = 1'b0;
        tick();
        chk(sw_code == 0, "R6 enable drop", int'(sw_code), 0);
        enable = 1'b1;
        ticks(100);
        rst_n = 1'b0;
        tick();
        chk(sw_code == 0 && lin_code == 0, "R1 reset mid ramp", int'(sw_code), 0);
        rst_n = 1'b1;
        ticks(FINAL * STEP + LAG + 10);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule